// File: doc/BRIEF.md
# ADC user conversion sequencer

This block sits between a register bus and a multi-channel analog-to-digital converter and decides which channel the converter samples next. Software loads a row of eight 4-bit slots, each naming a channel, enables the channels it wants, and chooses between two orderings. In user mode the slots are walked from slot 0 upward. In plain mode every enabled channel is converted in ascending index order. A slot that names a channel above 3, or a channel that is not enabled, contributes nothing.

One trigger pulse starts a whole pass. Each conversion is requested on a request/done handshake. The request and its channel are held until the converter answers with a one-cycle done. The block then moves straight to the next included entry and emits a one-cycle completion pulse after the last one. The mode, slots and enables are captured when the trigger is accepted, so software may rewrite them during a pass without affecting it. A trigger that lands during a pass is dropped and latched as an overrun. A write-protect bit freezes the slot register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four register addresses read 0, `conv_req` is low and `seq_done` is low.
- R2: Address 1 holds the slots. Slot k occupies bits 4k+3..4k, and a write to address 1 reads back unchanged.
- R3: Address 0 bit 1 is write protect and bit 0 is user-mode enable. While bit 1 is set, writes to address 1 are ignored. Address 0 stays writable at all times.
- R4: With user mode off, one trigger converts every channel whose bit is set at address 2 (bit n enables channel n), once each, in ascending order.
- R5: With user mode on, one trigger visits slots 0 to 7 in order. It requests the slot's value as the channel only if that value is 0 to 3 and its enable bit is set. Any other slot is skipped.
- R6: A channel named in several slots, adjacent or not, is converted once per such slot within the same triggered pass.
- R7: `conv_req` stays high with `conv_chan` stable until `conv_done` is seen. There is no gap between back-to-back requests of one pass.
- R8: `seq_done` is a single-cycle pulse in the cycle after the last `conv_done` of a pass. If no entry is included, it pulses in the cycle after the trigger and no request is made.
- R9: A trigger while `conv_req` is high is ignored and sets a sticky overrun flag. The flag appears on `overrun` and at address 3 bit 1, and writing 1 to address 3 bit 1 clears it. Address 3 bit 0 reads high while a pass is running.
- R10: Register writes during a pass do not change the channels requested by that pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| trigger | input | 1 | Starts a conversion pass |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Channel to convert |
| conv_done | input | 1 | One-cycle completion from the converter |
| seq_done | output | 1 | One-cycle end-of-pass pulse |
| overrun | output | 1 | Sticky flag for a trigger dropped during a pass |

## Verification
The hardest situations to reach are those where something changes while a pass is in flight: a second trigger or a slot rewrite arriving while a request is being held. The bench's converter model stretches its answer over several cycles. During that window it injects the trigger or bus write on a chosen cycle and then compares the full list of requested channels against the list expected from the settings captured at the start. The same model varies its latency between passes, which exercises back-to-back requests and empty passes as well as long holds.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NSLOT = 8,
  parameter int NCH   = 8,
  parameter int CHW   = 4,
  parameter int NUSER = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           trigger,
  output logic           conv_req,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  output logic           seq_done,
  output logic           overrun
);
  localparam int SLW  = NSLOT * CHW;
  localparam int NPOS = (NSLOT > NCH) ? NSLOT : NCH;
  localparam int PW   = $clog2(NPOS);

  logic           useq_q, wp_q, ovr_q, req_q, done_q, snap_useq;
  logic [SLW-1:0] slot_q, snap_slot;
  logic [NCH-1:0] chen_q, snap_chen;
  logic [PW-1:0]  pos_q, first_pos, nxt_pos;
  logic [CHW-1:0] chan_q;
  logic           first_found, nxt_found;
  logic           unused_bits;

  function automatic logic [CHW-1:0] chan_of(input logic um, input logic [SLW-1:0] sl, input int p);
    if (um && p < NSLOT) return sl[p*CHW +: CHW];
    return CHW'(p);
  endfunction

  function automatic logic pos_ok(input logic um, input logic [SLW-1:0] sl,
                                  input logic [NCH-1:0] ce, input int p);
    logic [CHW-1:0] c;
    logic ok;
    ok = 1'b0;
    c = chan_of(um, sl, p);
    for (int k = 0; k < NCH; k++)
      if (int'(c) == k && ce[k] && (!um || k < NUSER)) ok = 1'b1;
    if (um && p >= NSLOT) ok = 1'b0;
    if (!um && p >= NCH) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    first_found = 1'b0;
    first_pos   = '0;
    nxt_found   = 1'b0;
    nxt_pos     = '0;
    for (int p = NPOS - 1; p >= 0; p--) begin
      if (pos_ok(useq_q, slot_q, chen_q, p)) begin
        first_found = 1'b1;
        first_pos   = PW'(p);
      end
      if (p > int'(pos_q) && pos_ok(snap_useq, snap_slot, snap_chen, p)) begin
        nxt_found = 1'b1;
        nxt_pos   = PW'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      useq_q    <= 1'b0;
      wp_q      <= 1'b0;
      slot_q    <= '0;
      chen_q    <= '0;
      ovr_q     <= 1'b0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
      pos_q     <= '0;
      chan_q    <= '0;
      snap_useq <= 1'b0;
      snap_slot <= '0;
      snap_chen <= '0;
    end else begin
      done_q <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          2'd0: {wp_q, useq_q} <= reg_wdata[1:0];
          2'd1: if (!wp_q) slot_q <= reg_wdata[SLW-1:0];
          2'd2: chen_q <= reg_wdata[NCH-1:0];
          default: if (reg_wdata[1]) ovr_q <= 1'b0;
        endcase
      end
      if (trigger && req_q) ovr_q <= 1'b1;
      if (trigger && !req_q) begin
        snap_useq <= useq_q;
        snap_slot <= slot_q;
        snap_chen <= chen_q;
        if (first_found) begin
          req_q  <= 1'b1;
          pos_q  <= first_pos;
          chan_q <= chan_of(useq_q, slot_q, int'(first_pos));
        end else begin
          done_q <= 1'b1;
        end
      end
      if (req_q && conv_done) begin
        if (nxt_found) begin
          pos_q  <= nxt_pos;
          chan_q <= chan_of(snap_useq, snap_slot, int'(nxt_pos));
        end else begin
          req_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, wp_q, useq_q};
      2'd1:    reg_rdata = 32'(slot_q);
      2'd2:    reg_rdata = 32'(chen_q);
      default: reg_rdata = {30'd0, ovr_q, req_q};
    endcase
  end

  assign unused_bits = ^reg_wdata;
  assign conv_req    = req_q;
  assign conv_chan   = chan_q;
  assign seq_done    = done_q;
  assign overrun     = ovr_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int NSLOT = 8,
  parameter int NCH   = 8,
  parameter int CHW   = 4,
  parameter int NUSER = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [1:0]           reg_addr,
  input logic                 trigger,
  input logic                 conv_req,
  input logic [CHW-1:0]       conv_chan,
  input logic                 conv_done,
  input logic                 seq_done,
  input logic                 overrun,
  input logic                 wp_q,
  input logic [NSLOT*CHW-1:0] slot_q,
  input logic                 snap_useq,
  input logic [NCH-1:0]       snap_chen
);
  localparam int CIW = $clog2(NCH);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(conv_chan)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !conv_req); // R8
  AST_USER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && snap_useq |-> int'(conv_chan) < NUSER); // R5
  AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> int'(conv_chan) < NCH && snap_chen[conv_chan[CIW-1:0]]); // R4
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd1 && wp_q |=> $stable(slot_q)); // R3
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trigger && conv_req |=> overrun); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !(reg_we && reg_addr == 2'd3) |=> overrun); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NSLOT(NSLOT), .NCH(NCH), .CHW(CHW), .NUSER(NUSER)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .trigger(trigger),
  .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done), .seq_done(seq_done),
  .overrun(overrun), .wp_q(wp_q), .slot_q(slot_q), .snap_useq(snap_useq), .snap_chen(snap_chen)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, reg_we, trigger, conv_done;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic conv_req, seq_done, overrun;
  logic [3:0] conv_chan;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trigger(trigger), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_done(conv_done), .seq_done(seq_done), .overrun(overrun)
  );

  // {user mode, enables[7:0], slots[31:0], count[3:0], expected channels, first in low nibble}
  localparam logic [76:0] VEC [8] = '{
    {1'b0, 8'hA5, 32'h00000000, 4'd4, 32'h00007520},
    {1'b1, 8'h0F, 32'h32100123, 4'd8, 32'h32100123},
    {1'b1, 8'h05, 32'h32100123, 4'd4, 32'h00002002},
    {1'b1, 8'hFF, 32'h7153F914, 4'd3, 32'h00000131},
    {1'b1, 8'h02, 32'h11111111, 4'd8, 32'h11111111},
    {1'b0, 8'h00, 32'h00000000, 4'd0, 32'h00000000},
    {1'b1, 8'h08, 32'h00000000, 4'd0, 32'h00000000},
    {1'b0, 8'hFF, 32'h00000000, 4'd8, 32'h76543210}
  };

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [3:0] got [16];
  int got_n, gap;
  bit hold_bad, timed_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] packed_got();
    logic [31:0] s = '0;
    for (int k = 0; k < got_n && k < 8; k++) s[4*k +: 4] = got[k];
    return s;
  endfunction

  task automatic run_seq(input int lat, input int inj, input int modc, input logic [31:0] modv);
    int cnt = 0, cyc = 0, last_done = 0;
    bit prev_req = 0, done_was;
    logic [3:0] prev = '0;
    got_n = 0; hold_bad = 0; timed_out = 0; gap = -1;
    @(negedge clk);
    trigger = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      trigger = 1'b0;
      reg_we = 1'b0;
      done_was = conv_done;
      conv_done = 1'b0;
      if (seq_done) begin gap = cyc - last_done; break; end
      if (cyc > 500) begin timed_out = 1; break; end
      if (prev_req && conv_req && !done_was && conv_chan != prev) hold_bad = 1;
      if (conv_req) begin
        cnt++;
        if (cnt >= lat) begin
          conv_done = 1'b1;
          if (got_n < 16) got[got_n] = conv_chan;
          got_n++;
          cnt = 0;
          last_done = cyc;
        end
      end
      prev_req = conv_req;
      prev = conv_chan;
      if (cyc == inj && conv_req) trigger = 1'b1;
      if (cyc == modc) begin reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = modv; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; trigger = 1'b0; conv_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 0, "R1", "reset register read", 64'(d), 0);
    end
    chk(!conv_req && !seq_done, "R1", "reset outputs", {62'd0, conv_req, seq_done}, 0);

    for (int i = 0; i < 8; i++) begin
      logic [76:0] v = VEC[i];
      string tag;
      tag = (i == 2 || i == 4) ? "R6" : (v[35:32] == 0 ? "R8" : (v[76] ? "R5" : "R4"));
      wr(2'd0, {31'd0, v[76]});
      wr(2'd2, {24'd0, v[75:68]});
      wr(2'd1, v[67:36]);
      rd(2'd1, d);
      chk(d == v[67:36], "R2", "slot readback", 64'(d), 64'(v[67:36]));
      run_seq(1 + i % 3, 0, 0, 32'd0);
      chk(!timed_out && got_n == int'(v[35:32]), tag, "request count", 64'(got_n), 64'(v[35:32]));
      chk(packed_got() == v[31:0], tag, "channel order", 64'(packed_got()), 64'(v[31:0]));
      chk(gap == 1, "R8", "completion timing", 64'(gap), 1);
    end
    rd(2'd3, d);
    chk(d == 0, "R9", "no overrun from idle triggers", 64'(d), 0);

    wr(2'd1, 32'h12345670);
    wr(2'd0, 32'd2);
    wr(2'd1, 32'hFFFFFFFF);
    rd(2'd1, d);
    chk(d == 32'h12345670, "R3", "protected slot write ignored", 64'(d), 64'h12345670);
    rd(2'd0, d);
    chk(d == 32'd2, "R3", "mode readback", 64'(d), 2);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'hAAAAAAAA);
    rd(2'd1, d);
    chk(d == 32'hAAAAAAAA, "R3", "unprotected slot write", 64'(d), 64'hAAAAAAAA);

    wr(2'd2, 32'h01);
    run_seq(20, 0, 0, 32'd0);
    chk(!hold_bad && got_n == 1 && got[0] == 0, "R7", "held request", {31'd0, hold_bad, 32'(got_n)}, 1);
    chk(gap == 1, "R7", "done after long hold", 64'(gap), 1);

    wr(2'd2, 32'h0F);
    run_seq(4, 2, 0, 32'd0);
    chk(got_n == 4 && packed_got() == 32'h3210, "R9", "pass unaffected by extra trigger",
        64'(packed_got()), 64'h3210);
    chk(overrun == 1'b1, "R9", "overrun output", 64'(overrun), 1);
    rd(2'd3, d);
    chk(d == 32'd2, "R9", "overrun status bit", 64'(d), 2);
    wr(2'd3, 32'd2);
    rd(2'd3, d);
    chk(d == 32'd0 && !overrun, "R9", "overrun cleared", 64'(d), 0);

    wr(2'd0, 32'd1);
    wr(2'd1, 32'h44443210);
    run_seq(3, 0, 3, 32'h11111111);
    chk(got_n == 4 && packed_got() == 32'h3210, "R10", "captured settings", 64'(packed_got()), 64'h3210);
    rd(2'd1, d);
    chk(d == 32'h11111111, "R10", "mid-pass write landed", 64'(d), 64'h11111111);

    wr(2'd2, 32'h0F);
    run_seq(2, 0, 0, 32'd0);
    chk(packed_got() == 32'h11111111 && got_n == 8, "R6", "repeats after rewrite",
        64'(packed_got()), 64'h11111111);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule